// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block runs on the common source clock that feeds the bank A and bank C clock dividers. From the two divide ratios it works out where the next rising edge shared by both bank clocks will fall. It then drives an active-low sync output that warns of that edge. The low pulse lasts one period of whichever bank clock is faster, and it ends exactly on the shared edge.

The block has to give the right answer when the two periods are not integer multiples of each other, for example 3:2 or 5:3. It must also work when one ratio is a multiple of the other, or when both are equal. Each bank is tracked with its own phase counter. A bank clock is taken to rise in every source-clock cycle in which its phase count is 0. Both counts start at 0 together in the first cycle after reset is released, and again at each restart that follows a ratio change.

A ratio change is not applied at once. It waits for the next shared edge of the old pair of ratios. A separate enable input freezes the output low without producing a short high level.

Top module: `coin_sync_gen`

## Requirements
- R1: While reset is asserted, and in the first source-clock cycle after it is released (phase 0), sync_n is 1.
- R2: Each low pulse lasts exactly F source-clock cycles, where F is the smaller of the two divide ratios.
- R3: sync_n rises only in a cycle where both bank phase counts are 0, which is a shared rising edge.
- R4: For unequal ratios a and c with lowest common multiple L, phase p counts cycles since the restart, and sync_n is 0 exactly when (p mod L) >= L - F. This holds for non-integer relations such as 3:2, 4:3 and 5:3.
- R5: When the two ratios are equal (for example 1:1), the pattern period is 2F and sync_n is 0 exactly when (p mod 2F) >= F. A pulse therefore comes before every second shared edge.
- R6: A ratio input of 0 behaves exactly as a ratio of 1.
- R7: After either ratio input changes, no new pulse starts. The new ratios take effect at the next shared edge of the old ratios, which becomes phase 0 for the new pattern, and the R4/R5 pattern then applies.
- R8: With sync_en at 0, sync_n is frozen at 0. Entering or leaving the frozen state only takes effect in a cycle where the unfrozen pulse is low, so no shortened high level is ever produced.
- R9: Ratios where one is an integer multiple of the other (2:1, 3:1, 4:1, 6:1) follow the R4 rule with no special case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common source clock of both bank dividers |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_a | input | DIV_W | Divide ratio of bank A (0 is read as 1) |
| ratio_c | input | DIV_W | Divide ratio of bank C (0 is read as 1) |
| sync_en | input | 1 | 1 = sync runs, 0 = sync frozen low |
| sync_n | output | 1 | Active-low coincident-edge warning pulse |

## Verification
The bench builds the block with the default DIV_W of 5, so every ratio from 0 to 31 can be applied. With this width the table can cover the equal, integer-multiple and non-integer pairs, up to a common multiple of 24. The same width also allows a ratio of 1, which makes F a single source cycle, and a ratio of 0, which must behave as 1. Directed runs cover these cases:
- a change of ratios in the middle of a pattern;
- freezing and unfreezing at phases where the unfrozen pulse is high;
- a direct measurement of where one pulse falls and rises.

// File: rtl/csg_pkg.sv
package csg_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // number of tracked banks and their slots
   localparam int unsigned CSG_NBANK   = 2;
   localparam int unsigned CSG_BANK_A  = 0;
   localparam int unsigned CSG_BANK_C  = 1;

   // legal range of the ratio width
   localparam int unsigned CSG_MIN_DIV_W = 2;
   localparam int unsigned CSG_MAX_DIV_W = 8;
endpackage

// File: rtl/csg_bank_phase.sv
module csg_bank_phase #(
   parameter int unsigned DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] ratio_in,
   input  logic             restart,
   output logic             at_max,
   output logic             differs,
   output logic [DIV_W-1:0] cnt_now,
   output logic [DIV_W-1:0] cnt_nxt,
   output logic [DIV_W-1:0] act_nxt
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] act_q;
   logic [DIV_W-1:0] ratio_clean;

   // a zero ratio is read as divide-by-one
   assign ratio_clean = (ratio_in == '0) ? ONE : ratio_in;
   assign at_max      = (cnt_q == act_q - ONE);
   assign differs     = (ratio_clean != act_q);
   assign cnt_nxt     = at_max ? '0 : cnt_q + ONE;
   assign act_nxt     = restart ? ratio_clean : act_q;
   assign cnt_now     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= ONE;
      end else begin
         cnt_q <= cnt_nxt;
         act_q <= act_nxt;
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < act_q); // R4

   AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> $stable(act_q)); // R7
endmodule

// File: rtl/csg_pulse_shaper.sv
module csg_pulse_shaper #(
   parameter int unsigned DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] n_cnt_a,
   input  logic [DIV_W-1:0] n_cnt_c,
   input  logic [DIV_W-1:0] n_act_a,
   input  logic [DIV_W-1:0] n_act_c,
   input  logic             block,
   input  logic             sync_en,
   output logic             sync_n
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] fast_n;
   logic [DIV_W-1:0] rem_q, rem_d;
   logic             raw_q, raw_d;
   logic             en_q, en_d;
   logic             sync_q, out_d;
   logic             start_n;

   // period of the faster bank, in source cycles
   assign fast_n  = (n_act_a < n_act_c) ? n_act_a : n_act_c;
   // upcoming cycle lies F cycles ahead of a shared edge in both banks
   assign start_n = !block
                    && (n_cnt_a == n_act_a - fast_n)
                    && (n_cnt_c == n_act_c - fast_n);

   always_comb begin
      rem_d = '0;
      raw_d = 1'b1;
      if (rem_q != '0) begin
         rem_d = rem_q - ONE;
         raw_d = 1'b0;
      end else if (start_n && raw_q) begin
         // a start right after a pulse (equal ratios) is skipped
         rem_d = fast_n - ONE;
         raw_d = 1'b0;
      end
      // freeze state may only move while the pulse is low
      en_d  = raw_d ? en_q : sync_en;
      out_d = raw_d & en_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         raw_q  <= 1'b1;
         en_q   <= 1'b1;
         sync_q <= 1'b1;
      end else begin
         rem_q  <= rem_d;
         raw_q  <= raw_d;
         en_q   <= en_d;
         sync_q <= out_d;
      end
   end

   assign sync_n = sync_q;

   AST_COUNTDOWN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_q != '0) |-> !raw_q); // R2

   AST_NO_CUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_q) |-> !raw_q); // R8
endmodule

// File: rtl/coin_sync_gen.sv
module coin_sync_gen #(
   parameter int unsigned DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] ratio_a,
   input  logic [DIV_W-1:0] ratio_c,
   input  logic             sync_en,
   output logic             sync_n
);
   timeunit 1ns;
   timeprecision 1ps;

   import csg_pkg::*;

   generate
      if (DIV_W < CSG_MIN_DIV_W || DIV_W > CSG_MAX_DIV_W) begin : g_bad_width
         $error("coin_sync_gen: DIV_W out of supported range");
      end
   endgenerate

   logic [DIV_W-1:0]     ratio_v   [CSG_NBANK];
   logic [DIV_W-1:0]     cnt_v     [CSG_NBANK];
   logic [DIV_W-1:0]     cnt_nxt_v [CSG_NBANK];
   logic [DIV_W-1:0]     act_nxt_v [CSG_NBANK];
   logic [CSG_NBANK-1:0] at_max_v;
   logic [CSG_NBANK-1:0] differs_v;
   logic                 restart;
   logic                 pending;
   logic                 first_q;
   logic                 block;

   assign ratio_v[CSG_BANK_A] = ratio_a;
   assign ratio_v[CSG_BANK_C] = ratio_c;

   // every bank at its last cycle: next cycle is a shared rising edge
   assign restart = &at_max_v;
   assign pending = |differs_v;
   assign block   = pending | first_q;

   genvar gi;
   generate
      for (gi = 0; gi < CSG_NBANK; gi++) begin : g_bank
         csg_bank_phase #(.DIV_W(DIV_W)) u_phase (
            .clk      (clk),
            .rst_n    (rst_n),
            .ratio_in (ratio_v[gi]),
            .restart  (restart),
            .at_max   (at_max_v[gi]),
            .differs  (differs_v[gi]),
            .cnt_now  (cnt_v[gi]),
            .cnt_nxt  (cnt_nxt_v[gi]),
            .act_nxt  (act_nxt_v[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) first_q <= 1'b1;
      else        first_q <= 1'b0;
   end

   csg_pulse_shaper #(.DIV_W(DIV_W)) u_shaper (
      .clk     (clk),
      .rst_n   (rst_n),
      .n_cnt_a (cnt_nxt_v[CSG_BANK_A]),
      .n_cnt_c (cnt_nxt_v[CSG_BANK_C]),
      .n_act_a (act_nxt_v[CSG_BANK_A]),
      .n_act_c (act_nxt_v[CSG_BANK_C]),
      .block   (block),
      .sync_en (sync_en),
      .sync_n  (sync_n)
   );

   AST_RISE_ON_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_n) |-> (cnt_v[CSG_BANK_A] == '0 && cnt_v[CSG_BANK_C] == '0)); // R3

   AST_HIGH_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && sync_n) |=> sync_n); // R7
endmodule

// File: tb/coin_sync_gen_bench.sv
module coin_sync_gen_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned DIV_W = 5;
   localparam int NV = 10;
   // stimulus table: ratio pairs walked by one loop
   localparam int VA [NV] = '{4, 4, 6, 6, 8, 8, 12, 5, 1, 1};
   localparam int VC [NV] = '{4, 2, 2, 4, 2, 6,  2, 3, 1, 3};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] ra = '0;
   logic [DIV_W-1:0] rc = '0;
   logic             en = 1'b1;
   logic             sync_n;
   int               nchk = 0;
   int               nerr = 0;
   bit               done = 1'b0;

   always #2.5 clk = ~clk;

   coin_sync_gen #(.DIV_W(DIV_W)) u_coin_sync_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .ratio_a (ra),
      .ratio_c (rc),
      .sync_en (en),
      .sync_n  (sync_n)
   );

   function automatic int gcd(input int x, input int y);
      int a = x;
      int b = y;
      while (b != 0) begin
         int t = a % b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   // expected unfrozen level at phase p
   function automatic bit exp_raw(input int p, input int a0, input int c0);
      int a = (a0 == 0) ? 1 : a0;
      int c = (c0 == 0) ? 1 : c0;
      int f = (a < c) ? a : c;
      int per = (a == c) ? 2 * a : (a / gcd(a, c)) * c;
      int q = p % per;
      return !(q >= per - f);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ends right after the negedge that shows phase 0
   task automatic do_reset(input int a, input int c);
      rst_n = 1'b0;
      en = 1'b1;
      ra = DIV_W'(a);
      rc = DIV_W'(c);
      repeat (3) @(negedge clk);
      check("R1 sync high in reset", int'(sync_n), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 sync high at phase 0", int'(sync_n), 1);
   endtask

   // compares n phases against the model; freeze drops after sample
   // at phase drop_at and returns after sample at raise_at (-1: never)
   task automatic run_model(input string req, input int a, input int c,
                            input int n, input int drop_at, input int raise_at);
      bit en_l = 1'b1;
      int bad = 0;
      int first_p = -1;
      int first_act = 0;
      int first_exp = 0;
      for (int p = 0; p < n; p++) begin
         bit raw = exp_raw(p, a, c);
         bit e;
         if (!raw) en_l = en;
         e = raw & en_l;
         if (sync_n !== e) begin
            if (bad == 0) begin
               first_p = p;
               first_act = int'(sync_n);
               first_exp = int'(e);
            end
            bad++;
         end
         if (p == drop_at)  en = 1'b0;
         if (p == raise_at) en = 1'b1;
         @(negedge clk);
      end
      nchk++;
      if (bad != 0) begin
         nerr++;
         $display("FAIL %s ratios %0d:%0d phase %0d: actual %0d expected %0d",
                  req, a, c, first_p, first_act, first_exp);
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog (all requirements): actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int fall_p;
      int rise_p;
      bit prev;

      // table walk: equal, multiple and non-integer pairs
      for (int i = 0; i < NV; i++) begin
         string tag;
         if (VA[i] == VC[i])                              tag = "R5";
         else if (VA[i] % VC[i] == 0 || VC[i] % VA[i] == 0) tag = "R9";
         else                                             tag = "R4";
         do_reset(VA[i], VC[i]);
         run_model(tag, VA[i], VC[i], 80, -1, -1);
      end

      // R6: zero ratio read as one
      do_reset(0, 3);
      run_model("R6", 1, 3, 40, -1, -1);

      // R2 and R3: measure one pulse at 8:6 (window 18..23, rise at 24)
      do_reset(8, 6);
      fall_p = -1;
      rise_p = -1;
      prev = sync_n;
      for (int p = 1; p < 40; p++) begin
         @(negedge clk);
         if (prev && !sync_n && fall_p < 0) fall_p = p;
         if (!prev && sync_n && rise_p < 0) rise_p = p;
         prev = sync_n;
      end
      check("R2 pulse width", rise_p - fall_p, 6);
      check("R3 rise phase", rise_p, 24);

      // R7: change 4:2 -> 6:4 at phase 1, restart after old phase 3
      do_reset(4, 2);
      @(negedge clk);
      check("R7 phase 1 before change", int'(sync_n), 1);
      ra = DIV_W'(6);
      rc = DIV_W'(4);
      @(negedge clk);
      check("R7 held high while pending", int'(sync_n), 1);
      @(negedge clk);
      check("R7 held high at old window end", int'(sync_n), 1);
      @(negedge clk);
      run_model("R7 new pattern", 6, 4, 40, -1, -1);

      // R8: freeze entered and left at phases where sync is high
      do_reset(6, 4);
      run_model("R8", 6, 4, 60, 1, 30);
      // R8: freeze dropped in the middle of a window
      do_reset(6, 4);
      run_model("R8 mid window", 6, 4, 50, 9, 40);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule